// File: doc/BRIEF.md
# Processor Bus Arbitration Controller

This block sits beside a processor's bus cycle sequencer and decides when the processor hands the shared system bus to an external master. External masters drive one wired-OR request line, so any number of them may ask at once. The processor ranks below all of them, but it never gives up the bus in the middle of a cycle. It waits until its current cycle ends, then asserts grant. It keeps its own sequencer from starting new cycles until the external side has fully let go.

A mode input picks one of two handshakes. In three-wire mode the winning master answers grant with an acknowledge. Grant is then withdrawn after a programmable delay. If requests are still pending, grant is re-issued after a second delay, while the current owner still drives the bus, so that outside priority logic can pick the next owner early. A request that disappears before any acknowledge is treated as noise, and the processor keeps the bus. In two-wire mode acknowledge is ignored, and grant is held until the request line goes quiet. Request and acknowledge are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops (default 2). Both delays count clocks after synchronization.

Top module: `bus_arb_ctrl`

## Requirements
- R1: During and right after reset, `bus_grant` is 0 and `cpu_cyc_en` is 1 while request and acknowledge are low.
- R2: While `cpu_cyc_busy` is 1, a pending request does not raise `bus_grant`. Grant rises on the first clock edge at which the processor's cycle has ended.
- R3: With the processor idle, a request driven just after a clock edge raises `bus_grant` after SYNC_STAGES+2 rising edges.
- R4: In three-wire mode (`two_wire_mode`=0), `bus_grant` falls SYNC_STAGES+REL_DLY rising edges after the acknowledge input goes high.
- R5: In three-wire mode, if the request is still high when grant falls, `bus_grant` rises again REGRANT_DLY edges later, even while acknowledge stays high. It then stays high until the current owner drops acknowledge and the next owner raises it.
- R6: In three-wire mode, if the request drops while grant is high and no acknowledge has come, `bus_grant` falls SYNC_STAGES+1 edges after the drop, and the processor keeps the bus.
- R7: In two-wire mode (`two_wire_mode`=1), acknowledge has no effect. `bus_grant` stays high while the request is high and falls SYNC_STAGES+1 edges after the request drops.
- R8: `cpu_cyc_en` is 0 from the moment the synchronized request is seen (SYNC_STAGES edges after it is driven) until grant, request and (in three-wire mode) acknowledge are all low again. After the last of them clears, it returns to 1 within SYNC_STAGES+1 edges. Grant only rises after `cpu_cyc_en` has already been 0 for a cycle.
- R9: When no request is pending at the moment grant falls, grant is not re-issued, and the processor gets the bus back once acknowledge is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 1 | Wired-OR bus request from all external masters, active high, asynchronous |
| ext_ack | input | 1 | Grant acknowledge from the new owner, active high, asynchronous |
| cpu_cyc_busy | input | 1 | Processor bus cycle in progress, synchronous |
| two_wire_mode | input | 1 | 1 = request/grant only, 0 = request/grant/acknowledge |
| bus_grant | output | 1 | Bus grant to the external masters, active high |
| cpu_cyc_en | output | 1 | 1 = processor may start a new bus cycle |

## Verification
The checker watches four rules on every cycle. Grant only rises at a cycle boundary and after the processor enable has already dropped. In two-wire mode grant never falls while the request is held. Grant never falls unless the request has gone or a three-wire acknowledge was seen. Any grant whose request and acknowledge have both gone is dropped. The exact latencies can only be shown by the bench's scenarios: the synchronizer depth plus the release and re-grant delays, the early re-grant under a held acknowledge, the spurious-request recovery, and the enable's return.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_END  = 3'd1,
    ST_GRANTED   = 3'd2,
    ST_EXT_OWNS  = 3'd3,
    ST_REGRANT   = 3'd4
  } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/arb_delay.sv
module arb_delay #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;
  always_comb begin
    if (clr || !run) cnt_nxt = '0;
    else             cnt_nxt = cnt + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
#(
  parameter int REL_DLY     = 3,
  parameter int REGRANT_DLY = 2,
  parameter int CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic             ack_s,
  input  logic             cyc_busy,
  input  logic             two_wire,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_run,
  output logic             grant,
  output logic             cyc_en
);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_DLY - 1);
  localparam logic [CNT_W-1:0] RGT_LAST = CNT_W'(REGRANT_DLY - 1);

  arb_state_e state, state_nxt;
  logic       ack_eff;

  // acknowledge only counts in three-wire mode
  assign ack_eff = ack_s & ~two_wire;

  always_comb begin
    state_nxt = state;
    cnt_run   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_s) state_nxt = ST_WAIT_END;
      end
      ST_WAIT_END: begin
        if (!req_s)         state_nxt = ST_IDLE;
        else if (!cyc_busy) state_nxt = ST_GRANTED;
      end
      ST_GRANTED: begin
        if (ack_eff) begin
          cnt_run = 1'b1;
          if (cnt == REL_LAST) state_nxt = ST_EXT_OWNS;
        end else if (!req_s) begin
          state_nxt = ST_IDLE;
        end
      end
      ST_EXT_OWNS: begin
        if (req_s) begin
          cnt_run = 1'b1;
          if (cnt == RGT_LAST) state_nxt = ST_REGRANT;
        end else if (!ack_eff) begin
          state_nxt = ST_IDLE;
        end
      end
      ST_REGRANT: begin
        if (!ack_eff) state_nxt = req_s ? ST_GRANTED : ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign cnt_clr = (state_nxt != state);
  assign grant   = (state == ST_GRANTED) || (state == ST_REGRANT);
  assign cyc_en  = (state == ST_IDLE) && !req_s && !ack_eff;
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int REL_DLY     = 3,
  parameter int REGRANT_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic ext_ack,
  input  logic cpu_cyc_busy,
  input  logic two_wire_mode,
  output logic bus_grant,
  output logic cpu_cyc_en
);
  localparam int MAX_DLY = (REL_DLY > REGRANT_DLY) ? REL_DLY : REGRANT_DLY;
  localparam int CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);

  logic [1:0]       sync_q;
  logic             req_s, ack_s;
  logic             cnt_clr, cnt_run;
  logic [CNT_W-1:0] cnt;

  arb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ext_ack, ext_req}), .dout(sync_q)
  );
  assign req_s = sync_q[0];
  assign ack_s = sync_q[1];

  arb_delay #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run), .cnt(cnt)
  );

  arb_fsm #(.REL_DLY(REL_DLY), .REGRANT_DLY(REGRANT_DLY), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .ack_s(ack_s),
    .cyc_busy(cpu_cyc_busy), .two_wire(two_wire_mode), .cnt(cnt),
    .cnt_clr(cnt_clr), .cnt_run(cnt_run), .grant(bus_grant), .cyc_en(cpu_cyc_en)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk (
  input logic clk,
  input logic rst_n,
  input logic req_s,
  input logic ack_s,
  input logic cyc_busy,
  input logic two_wire,
  input logic grant,
  input logic cyc_en
);
  a_r2_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> !$past(cyc_busy));

  a_r8_en_low_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> !$past(cyc_en));

  a_r7_two_wire_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (two_wire && grant && req_s) |=> grant);

  a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant) |-> ($past(!req_s) || ($past(ack_s) && !$past(two_wire))));

  a_r6_drop_orphan_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_s && !(ack_s && !two_wire)) |=> !grant);
endmodule

bind bus_arb_ctrl arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .ack_s(ack_s),
  .cyc_busy(cpu_cyc_busy), .two_wire(two_wire_mode),
  .grant(bus_grant), .cyc_en(cpu_cyc_en)
);

// File: tb/bus_arb_ctrl_tb.sv
module bus_arb_ctrl_tb;
  localparam int SYNC = 2;
  localparam int REL  = 3;
  localparam int RGT  = 2;

  logic clk = 1'b0;
  logic rst_n, ext_req, ext_ack, cpu_cyc_busy, two_wire_mode;
  logic bus_grant, cpu_cyc_en;
  int   n_chk = 0, n_bad = 0, cyc_cnt = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  bus_arb_ctrl #(.SYNC_STAGES(SYNC), .REL_DLY(REL), .REGRANT_DLY(RGT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_ack(ext_ack),
    .cpu_cyc_busy(cpu_cyc_busy), .two_wire_mode(two_wire_mode),
    .bus_grant(bus_grant), .cpu_cyc_en(cpu_cyc_en)
  );

  // expected latencies, derived from the requirements
  function automatic int lat_grant();   return SYNC + 2;   endfunction
  function automatic int lat_release(); return SYNC + REL; endfunction
  function automatic int lat_drop();    return SYNC + 1;   endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; ext_req = 1'b0; ext_ack = 1'b0;
    cpu_cyc_busy = 1'b0; two_wire_mode = 1'b0;
    tick(3);
    chk(bus_grant, 1'b0, "R1 grant in reset");
    chk(cpu_cyc_en, 1'b1, "R1 enable in reset");
    rst_n = 1'b1;
    tick(2);
    chk(bus_grant, 1'b0, "R1 grant after reset");
    chk(cpu_cyc_en, 1'b1, "R1 enable after reset");

    // R3 / R8: grant latency with idle processor
    ext_req = 1'b1;
    tick(SYNC - 1);
    chk(cpu_cyc_en, 1'b1, "R8 enable before sync");
    tick(1);
    chk(cpu_cyc_en, 1'b0, "R8 enable drops on request");
    tick(lat_grant() - SYNC - 1);
    chk(bus_grant, 1'b0, "R3 grant one edge early");
    tick(1);
    chk(bus_grant, 1'b1, "R3 grant rises");

    // R4: release after acknowledge, another master still requesting
    ext_ack = 1'b1;
    tick(lat_release() - 1);
    chk(bus_grant, 1'b1, "R4 grant one edge before release");
    tick(1);
    chk(bus_grant, 1'b0, "R4 grant released");
    // R5: re-grant with acknowledge still held
    tick(RGT - 1);
    chk(bus_grant, 1'b0, "R5 regrant one edge early");
    tick(1);
    chk(bus_grant, 1'b1, "R5 regrant under held ack");
    chk(cpu_cyc_en, 1'b0, "R8 enable low during regrant");
    tick(4);
    chk(bus_grant, 1'b1, "R5 grant held while ack held");
    ext_ack = 1'b0;                       // current owner done
    tick(SYNC + 2);
    chk(bus_grant, 1'b1, "R5 grant kept for next owner");
    ext_ack = 1'b1; ext_req = 1'b0;       // next owner takes it, no more requests
    tick(lat_release() - 1);
    chk(bus_grant, 1'b1, "R4 second release early");
    tick(1);
    chk(bus_grant, 1'b0, "R4 second release");
    tick(RGT + 3);
    chk(bus_grant, 1'b0, "R9 no regrant without request");
    chk(cpu_cyc_en, 1'b0, "R8 enable low while ack held");
    ext_ack = 1'b0;
    tick(SYNC);
    chk(cpu_cyc_en, 1'b0, "R8 enable one edge early");
    tick(1);
    chk(cpu_cyc_en, 1'b1, "R9 bus returned to processor");

    // R6: spurious request
    ext_req = 1'b1;
    tick(lat_grant());
    chk(bus_grant, 1'b1, "R6 grant before drop");
    ext_req = 1'b0;
    tick(lat_drop() - 1);
    chk(bus_grant, 1'b1, "R6 grant one edge before withdraw");
    tick(1);
    chk(bus_grant, 1'b0, "R6 grant withdrawn");
    chk(cpu_cyc_en, 1'b1, "R6 processor keeps bus");

    // R2: wait for the processor cycle to end
    cpu_cyc_busy = 1'b1;
    tick(1);
    ext_req = 1'b1;
    for (int i = 0; i < 7; i++) begin
      tick(1);
      chk(bus_grant, 1'b0, "R2 no grant while busy");
    end
    cpu_cyc_busy = 1'b0;
    tick(1);
    chk(bus_grant, 1'b1, "R2 grant at cycle end");
    ext_req = 1'b0;
    tick(lat_drop() + 1);

    // R7: two-wire mode ignores acknowledge
    two_wire_mode = 1'b1;
    tick(1);
    ext_req = 1'b1;
    tick(lat_grant());
    chk(bus_grant, 1'b1, "R7 grant in two-wire");
    ext_ack = 1'b1;
    tick(lat_release() + RGT + 4);
    chk(bus_grant, 1'b1, "R7 ack ignored, grant held");
    ext_req = 1'b0;
    tick(lat_drop() - 1);
    chk(bus_grant, 1'b1, "R7 grant one edge before drop");
    tick(1);
    chk(bus_grant, 1'b0, "R7 grant drops with request");
    chk(cpu_cyc_en, 1'b1, "R7 enable despite ack");
    ext_ack = 1'b0;
    tick(SYNC + 1);
    two_wire_mode = 1'b0;
    tick(1);

    // random three-wire handshakes
    for (int it = 0; it < 24; it++) begin
      int busy_len, ack_wait;
      busy_len = 4 + int'($urandom_range(6));
      ack_wait = int'($urandom_range(5));
      cpu_cyc_busy = 1'b1;
      tick(1);
      ext_req = 1'b1;
      tick(busy_len);
      chk(bus_grant, 1'b0, "R2 random: held during busy");
      cpu_cyc_busy = 1'b0;
      tick(1);
      chk(bus_grant, 1'b1, "R2 random: grant at boundary");
      tick(ack_wait);
      chk(bus_grant, 1'b1, "R4 random: grant waits for ack");
      ext_ack = 1'b1; ext_req = 1'b0;
      tick(lat_release() - 1);
      chk(bus_grant, 1'b1, "R4 random: early");
      tick(1);
      chk(bus_grant, 1'b0, "R4 random: released");
      tick(int'($urandom_range(4)));
      ext_ack = 1'b0;
      tick(lat_drop());
      chk(cpu_cyc_en, 1'b1, "R9 random: bus back");
    end

    finish_run();
  end
endmodule